// File: doc/BRIEF.md
# System Control Register Bank

A bank of 32-bit global control and status words that answers a single-cycle register port inside a 4 KiB byte window. Each word follows one write rule, fixed by where it sits. Most words are plain read/write storage. Three are read-only. Two clear the bits where the written value holds ones. Two set the bits where the written value holds ones, so software can never clear them again.

A synchronous cold reset loads each word with its fixed start value. Three words take their start value from inputs instead. The power-on word copies a 32-bit strap input. The module-disable word copies a 32-bit configuration input. The third interrupt-control word encodes the installed DRAM size, which arrives as a 5-bit log2 of its size in bytes. Words past the last implemented one read as zero and ignore writes.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the words hold these values, keyed by byte offset; every other implemented word holds zero.

  | Byte offset | Value |
  |---|---|
  | 0x000 | 0x04A92750 |
  | 0x014 | 0x0000FFFF |
  | 0x038 | 0x00000003 |
  | 0x03C | 0x0000035E |
  | 0x050 | 0x0000004E |
  | 0x060 | 0x00080000 |
  | 0x06C | 0x80000000 |
  | 0x078 | 0x000000C0 |
  | 0x098 | 0x5A00F3CF |
  | 0x13C | 0x00000008 |
  | 0x140 | 0x034730E4 |
  | 0x144 | 0x034730E4 |

  The word at offset 0x000 never changes.
- R2: The word index is the byte address bits [11:2]. There are 82 implemented words, at offsets 0x000 to 0x144. A read at an index of 82 or more returns zero. A write at such an index changes no word.
- R3: Writes to the words at offsets 0x000, 0x004 and 0x040 are discarded.
- R4: A write to offset 0x06C or 0x0D4 leaves `old & ~wrData` in the word (write-one-to-clear).
- R5: A write to offset 0x070 or 0x07C leaves `old | wrData` in the word (write-one-to-set).
- R6: Reset loads the word at 0x004 from `strapPwr` and the word at 0x07C from `cfgModOff`.
- R7: Reset loads the word at 0x09C with `0x00001002 | ((dramLog2-27) << 8)` when `dramLog2` lies in 27..31, which is 128 MiB to 2 GiB. In that case `cfgError` is 0.
- R8: When `dramLog2` lies outside 27..31, `cfgError` is 1 and reset loads 0x00001002 at 0x09C.
- R9: A read presents its data on `rdData` in the cycle after the request. `rdData` holds its value in cycles with no read and is zero after reset.
- R10: A read and a write to the same word in one cycle return the value the word held before the write.
- R11: Every other implemented word is plain read/write storage. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| addr | input | 12 | Byte address within the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| strapPwr | input | 32 | Strap value for the power-on word |
| cfgModOff | input | 32 | Start value for the module-disable word |
| dramLog2 | input | 5 | log2 of the DRAM size in bytes |
| cfgError | output | 1 | DRAM size outside the supported range |

## Verification
Every implemented word, plus two indices past the end, is first read right after reset. This separates the fixed start values from the strap-seeded ones. Each word is then written with an index-dependent mixed pattern, then all ones, then all zeros, and read back after each write. This order tells the four write rules apart: a clear-on-one word ends at zero, a set-on-one word stays at all ones after the zero write, and a read-only word never moves. Further resets use DRAM log2 values below, at both ends of, and inside the valid range, which checks both the field encoding and the error flag. A read and a write in the same cycle, writes past the end, and address bits [1:0] that are not zero test the decode corners.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int NUM_REGS = 82;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int WORD_W   = ADDR_W - 2;

  localparam int IDX_PWRON  = 1;
  localparam int IDX_MODOFF = 31;
  localparam int IDX_DRAM   = 39;

  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_e;

  typedef struct packed {
    logic             wrGo;
    logic             rdGo;
    logic             rdOor;
    pol_e             pol;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  function automatic pol_e policyOf(input int idx);
    case (idx)
      0, 1, 16: return POL_RO;
      27, 53:   return POL_W1C;
      28, 31:   return POL_W1S;
      default:  return POL_RW;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] coldValue(input int idx);
    case (idx)
      0:       return 32'h04A9_2750;
      5:       return 32'h0000_FFFF;
      14:      return 32'h0000_0003;
      15:      return 32'h0000_035E;
      20:      return 32'h0000_004E;
      24:      return 32'h0008_0000;
      27:      return 32'h8000_0000;
      30:      return 32'h0000_00C0;
      38:      return 32'h5A00_F3CF;
      79:      return 32'h0000_0008;
      80, 81:  return 32'h0347_30E4;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_ctrl.sv
`timescale 1ns/1ps
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int DRAM_MIN_LOG2 = 27,
  parameter int DRAM_MAX_LOG2 = 31
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        dramLog2,
  output strobe_t           stb,
  output logic [DATA_W-1:0] dramSeed,
  output logic              cfgError
);
  logic [WORD_W-1:0] word;
  logic              inRange;
  logic              dramOk;
  logic              unusedLow;
  logic [4:0]        sizeCode;

  assign word      = addr[ADDR_W-1:2];
  assign unusedLow = ^addr[1:0];
  assign inRange   = (int'(word) < NUM_REGS);

  always_comb begin
    stb.idx   = word[IDX_W-1:0];
    stb.pol   = policyOf(int'(word));
    stb.wrGo  = wrEn && inRange && (stb.pol != POL_RO);
    stb.rdGo  = rdEn && inRange;
    stb.rdOor = rdEn && !inRange;
  end

  assign dramOk   = (int'(dramLog2) >= DRAM_MIN_LOG2) && (int'(dramLog2) <= DRAM_MAX_LOG2);
  assign sizeCode = dramOk ? (dramLog2 - 5'(DRAM_MIN_LOG2)) : 5'd0;
  assign dramSeed = 32'h0000_1002 | (32'(sizeCode) << 8);
  assign cfgError = !dramOk;
endmodule

// File: rtl/sysctl_datapath.sv
`timescale 1ns/1ps
module sysctl_datapath
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] strapPwr,
  input  logic [DATA_W-1:0] cfgModOff,
  input  logic [DATA_W-1:0] dramSeed,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regBank [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= coldValue(i);
      regBank[IDX_PWRON]  <= strapPwr;
      regBank[IDX_MODOFF] <= cfgModOff;
      regBank[IDX_DRAM]   <= dramSeed;
      rdData <= '0;
    end else begin
      if (stb.wrGo) begin
        case (stb.pol)
          POL_W1C: regBank[stb.idx] <= regBank[stb.idx] & ~wrData;
          POL_W1S: regBank[stb.idx] <= regBank[stb.idx] | wrData;
          POL_RW:  regBank[stb.idx] <= wrData;
          default: ;
        endcase
      end
      if (stb.rdGo)       rdData <= regBank[stb.idx];
      else if (stb.rdOor) rdData <= '0;
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int DRAM_MIN_LOG2 = 27,
  parameter int DRAM_MAX_LOG2 = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] strapPwr,
  input  logic [DATA_W-1:0] cfgModOff,
  input  logic [4:0]        dramLog2,
  output logic              cfgError
);
  strobe_t           stb;
  logic [DATA_W-1:0] dramSeed;

  sysctl_ctrl #(
    .DRAM_MIN_LOG2(DRAM_MIN_LOG2),
    .DRAM_MAX_LOG2(DRAM_MAX_LOG2)
  ) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .dramLog2(dramLog2),
    .stb(stb), .dramSeed(dramSeed), .cfgError(cfgError)
  );

  sysctl_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .strapPwr(strapPwr), .cfgModOff(cfgModOff), .dramSeed(dramSeed),
    .rdData(rdData)
  );
endmodule

// File: rtl/sysctl_regbank_chk.sv
`timescale 1ns/1ps
module sysctl_regbank_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [WORD_W-1:0] wordIdx,
  input logic [DATA_W-1:0] rdData,
  input logic [4:0]        dramLog2,
  input logic              cfgError
);
  p_oor_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rdEn && int'(wordIdx) >= NUM_REGS) |=> (rdData == '0));

  p_pid_const_r1: assert property (@(posedge clk) disable iff (rst)
    (rdEn && wordIdx == '0) |=> (rdData == 32'h04A9_2750));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  p_reset_zero_r9: assert property (@(posedge clk)
    rst |=> (rdData == '0));

  p_size_bad_r8: assert property (@(posedge clk) disable iff (rst)
    (dramLog2 < 5'd27 || dramLog2 > 5'd31) |-> cfgError);

  p_size_good_r7: assert property (@(posedge clk) disable iff (rst)
    (dramLog2 >= 5'd27 && dramLog2 <= 5'd31) |-> !cfgError);
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .wordIdx(addr[11:2]),
  .rdData(rdData), .dramLog2(dramLog2), .cfgError(cfgError)
);

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0, strapPwr = '0, cfgModOff = '0;
  logic [4:0]  dramLog2 = 5'd27;
  logic [31:0] rdData;
  logic        cfgError;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model [0:81];
  logic [31:0] expRd = '0;

  always #10 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strapPwr(strapPwr),
    .cfgModOff(cfgModOff), .dramLog2(dramLog2), .cfgError(cfgError)
  );

  function automatic string tagFor(input int w);
    if (w >= 82) return "R2";
    case (w)
      0, 1, 16: return "R3";
      27, 53:   return "R4";
      28, 31:   return "R5";
      default:  return "R11";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic re, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    int w;
    @(negedge clk);
    wrEn = we; rdEn = re; addr = a; wrData = d;
    w = int'(a[11:2]);
    if (re) expRd = (w < 82) ? model[w] : 32'h0;
    if (we && w < 82) begin
      case (w)
        0, 1, 16: ;
        27, 53:   model[w] = model[w] & ~d;
        28, 31:   model[w] = model[w] | d;
        default:  model[w] = d;
      endcase
    end
    @(posedge clk); #1;
    check32(tag, rdData, expRd);
  endtask

  task automatic doReset(input logic [31:0] sp, input logic [31:0] mo, input logic [4:0] lg);
    bit ok;
    @(negedge clk);
    rst = 1'b1; wrEn = 0; rdEn = 0; strapPwr = sp; cfgModOff = mo; dramLog2 = lg;
    @(posedge clk); #1;
    for (int i = 0; i < 82; i++) model[i] = 32'h0;
    model['h000 >> 2] = 32'h04A92750;
    model['h004 >> 2] = sp;
    model['h014 >> 2] = 32'h0000FFFF;
    model['h038 >> 2] = 32'h00000003;
    model['h03C >> 2] = 32'h0000035E;
    model['h050 >> 2] = 32'h0000004E;
    model['h060 >> 2] = 32'h1 << 19;
    model['h06C >> 2] = 32'h80000000;
    model['h078 >> 2] = 32'h000000C0;
    model['h07C >> 2] = mo;
    model['h098 >> 2] = 32'h5A00F3CF;
    model['h13C >> 2] = 32'h00000008;
    model['h140 >> 2] = 32'h034730E4;
    model['h144 >> 2] = 32'h034730E4;
    ok = (lg >= 27 && lg <= 31);
    model['h09C >> 2] = 32'h1002 | (ok ? (32'(lg) - 32'd27) << 8 : 32'h0);
    expRd = 32'h0;
    check32("R9", rdData, 32'h0);
    check32(ok ? "R7" : "R8", {31'h0, cfgError}, {31'h0, !ok});
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    doReset(32'h1234_5678, 32'h0000_0F00, 5'd29);
    // R1 R6 R7: reset image, R2 two indices past the end
    for (int w = 0; w < 84; w++)
      step(0, 1, 12'(w * 4), 32'h0, (w == 1 || w == 31) ? "R6" : (w == 39 ? "R7" : (w >= 82 ? "R2" : "R1")));
    // R3 R4 R5 R11: three patterns per word
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 82; w++) begin
        step(1, 0, 12'(w * 4), (p == 0) ? (32'hA5A5_5A5A ^ 32'(w)) : (p == 1 ? 32'hFFFF_FFFF : 32'h0), tagFor(w));
        step(0, 1, 12'(w * 4), 32'h0, tagFor(w));
      end
    // R11: low address bits ignored
    step(1, 0, 12'h0C3, 32'hDEAD_BEEF, "R11");
    step(0, 1, 12'h0C1, 32'h0, "R11");
    // R10: same-cycle read and write
    step(1, 1, 12'h020, 32'h1111_2222, "R10");
    step(0, 1, 12'h020, 32'h0, "R10");
    // R9: hold with no read
    step(0, 0, 12'h000, 32'h0, "R9");
    step(1, 0, 12'h024, 32'h7777_0000, "R9");
    // R2: writes past the end change nothing
    step(1, 0, 12'h148, 32'hCAFE_F00D, "R2");
    step(1, 0, 12'hFFC, 32'hCAFE_F00D, "R2");
    step(0, 1, 12'h148, 32'h0, "R2");
    step(0, 1, 12'h008, 32'h0, "R2");
    step(0, 1, 12'h144, 32'h0, "R2");
    // R8: invalid DRAM sizes
    doReset(32'h0, 32'h0, 5'd26);
    step(0, 1, 12'h09C, 32'h0, "R8");
    doReset(32'h0, 32'h0, 5'd0);
    step(0, 1, 12'h09C, 32'h0, "R8");
    // R7: both range ends
    doReset(32'hFFFF_0000, 32'h1, 5'd31);
    step(0, 1, 12'h09C, 32'h0, "R7");
    step(0, 1, 12'h004, 32'h0, "R6");
    doReset(32'h0, 32'h0, 5'd27);
    step(0, 1, 12'h09C, 32'h0, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule